// File: doc/BRIEF.md
# Parallel Port Register and Interrupt Core

This block is the register core of a PC-style parallel port. It supports the plain output mode, a bidirectional mode and an extended control register. A host issues byte reads and writes through a simple strobe bus. The offset selects one of five registers: data at 0x000, status at 0x001, control at 0x002, a configuration readout at 0x401 and the extended control register at 0x402. The block holds the byte that drives the data pins and the bit that sets their direction. It passes the control bits to the pins. It assembles status from the peripheral inputs.

The block also produces one active-high, level-sensitive interrupt request. Three sources can raise it:
- the acknowledge pin, handled differently by mode;
- a falling edge on the error pin, when that source is unmasked;
- a FIFO service event supplied by external FIFO logic.

Before any edge detection, the acknowledge and error inputs each pass through a two-flop synchronizer. The FIFO storage, the pin drivers and the transfer handshakes are outside this block. They feed the block through the FIFO flag inputs and the data pin inputs.

Top module: `pport_core`

## Requirements
- R1: While control bit 5 is 0, `pd_oe_o` is 1, `pd_o` carries the last byte written at offset 0x000, and a read at that offset returns that byte.
- R2: While control bit 5 is 1, `pd_oe_o` is 0 and a read at offset 0x000 returns `pd_i`. The latched byte is kept and reappears when bit 5 returns to 0.
- R3: In bidirectional mode (extended control bits 7:5 = 001), a 0-to-1 transition of the synchronized `ack_ni` sets a pending flag, provided control bit 4 is 1. While control bit 4 is 1, that flag drives `irq_o`. A 1-to-0 transition of `ack_ni` raises nothing. While control bit 4 is 0, no acknowledge interrupt is raised.
- R4: In bidirectional mode, status bit 2 reads 0 while the acknowledge flag is pending. A read of the status register clears the flag, so `irq_o` falls after that read and the next status read returns bit 2 = 1.
- R5: In any other mode, status bit 2 reads 1, and the acknowledge term of `irq_o` equals control bit 4 AND NOT synchronized `ack_ni`.
- R6: Extended control bit 0 reads `fifo_empty_i` and bit 1 reads `fifo_full_i`. Writing 0x34 with the FIFO empty and not full reads back 0x35.
- R7: Writes to extended control bits 1:0 are ignored. Writing 0xF7 with the FIFO empty reads back 0xF5.
- R8: With extended control bits 7:5 = 111, offset 0x401 reads {0, `irq_o`, `irq_sel_i`[2:0], 000}. In any other mode, that offset reads 0xFF. Any unmapped offset also reads 0xFF.
- R9: When extended control bit 4 is 0, a 1-to-0 transition of the synchronized `err_ni` latches an interrupt. A status read clears it. When bit 4 is 1, such a transition is ignored.
- R10: When extended control bit 2 is 0 and `fifo_svc_i` is high at a clock edge, the bit becomes 1 and `irq_o` rises. A write to the extended control register clears that interrupt. When the bit is already 1, `fifo_svc_i` has no effect.
- R11: After reset, the following values hold:
  - the port is in output mode 000 with the data pins driven;
  - `irq_o` is 0;
  - control reads 0xC0;
  - extended control reads 0x15 when the FIFO is empty and not full.
- R12: Control reads {11, bits 5:0 as written}, and `ctl_o` carries bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_re_i | input | 1 | Read strobe; a status read clears latched events |
| bus_we_i | input | 1 | Write strobe |
| bus_addr_i | input | 11 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (combinational) |
| pd_i | input | 8 | Data pin values from the pads |
| pd_o | output | 8 | Data output latch |
| pd_oe_o | output | 1 | Data pin drive enable |
| ctl_o | output | 4 | Control lines, control bits 3:0 |
| ack_ni | input | 1 | Acknowledge pin, active low, asynchronous |
| err_ni | input | 1 | Error pin, active low, asynchronous |
| busy_i | input | 1 | Busy pin, read inverted in status bit 7 |
| pe_i | input | 1 | Paper-end pin, status bit 5 |
| slct_i | input | 1 | Select pin, status bit 4 |
| fifo_empty_i | input | 1 | FIFO empty flag |
| fifo_full_i | input | 1 | FIFO full flag |
| fifo_svc_i | input | 1 | FIFO threshold service event |
| irq_sel_i | input | 3 | Interrupt line selection code for the configuration readout |
| irq_o | output | 1 | Level interrupt request, active high |

## Verification
The acknowledge pin is driven through both edge directions in each of the two relevant modes. A leading edge that raises nothing separates true trailing-edge latching from simple mirroring. A status read that drops the request separates the read-to-clear path from the level-following path. Register traffic repeats the same write patterns across the data, control and extended control offsets, with both FIFO flag states applied. This shows whether the read-only bits come from the inputs or from storage. The error and FIFO sources are each tried masked and unmasked, which checks that every interrupt source is gated only by its own enable.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int unsigned ADDR_W = 11;
  localparam int unsigned DATA_W = 8;

  localparam logic [ADDR_W-1:0] OFF_DATA = 11'h000;
  localparam logic [ADDR_W-1:0] OFF_STAT = 11'h001;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 11'h002;
  localparam logic [ADDR_W-1:0] OFF_CFGB = 11'h401;
  localparam logic [ADDR_W-1:0] OFF_ECR  = 11'h402;

  localparam logic [2:0] MODE_SPP = 3'b000;
  localparam logic [2:0] MODE_PS2 = 3'b001;
  localparam logic [2:0] MODE_CFG = 3'b111;
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int unsigned W       = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q, p_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL;
        s2_q <= RST_VAL;
        p_q  <= RST_VAL;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
        p_q  <= s2_q;
      end
    end
    assign sync_o[g] = s2_q;
    assign prev_o[g] = p_q;
  end
endmodule

// File: rtl/pport_ecr.sv
module pport_ecr
  import pport_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              fifo_empty_i,
  input  logic              fifo_full_i,
  input  logic              fifo_svc_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [2:0]        mode_o,
  output logic              err_mask_o,
  output logic              svc_bit_o,
  output logic              svc_pend_o
);
  logic [2:0] mode_q;
  logic       err_mask_q, dma_en_q, svc_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_SPP;
      err_mask_q <= 1'b1;
      dma_en_q   <= 1'b0;
      svc_q      <= 1'b1;
      pend_q     <= 1'b0;
    end else if (we_i) begin
      mode_q     <= wdata_i[7:5];
      err_mask_q <= wdata_i[4];
      dma_en_q   <= wdata_i[3];
      svc_q      <= wdata_i[2];
      pend_q     <= 1'b0;
    end else if (fifo_svc_i && !svc_q) begin
      svc_q  <= 1'b1;
      pend_q <= 1'b1;
    end
  end

  assign rdata_o    = {mode_q, err_mask_q, dma_en_q, svc_q, fifo_full_i, fifo_empty_i};
  assign mode_o     = mode_q;
  assign err_mask_o = err_mask_q;
  assign svc_bit_o  = svc_q;
  assign svc_pend_o = pend_q;
endmodule

// File: rtl/pport_irq.sv
module pport_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ps2_i,
  input  logic ack_en_i,
  input  logic err_mask_i,
  input  logic ack_sync_i,
  input  logic ack_prev_i,
  input  logic err_sync_i,
  input  logic err_prev_i,
  input  logic stat_rd_i,
  input  logic svc_pend_i,
  output logic irq_o,
  output logic stat2_o,
  output logic ack_pend_o,
  output logic ack_rise_o
);
  logic ack_pend_q, err_pend_q;
  logic ack_rise, err_fall, ack_line;

  assign ack_rise = ack_sync_i & ~ack_prev_i;  // trailing edge of active-low pin
  assign err_fall = ~err_sync_i & err_prev_i;

  // a new event in the read cycle survives the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_pend_q <= 1'b0;
      err_pend_q <= 1'b0;
    end else begin
      if (ps2_i && ack_en_i && ack_rise) ack_pend_q <= 1'b1;
      else if (stat_rd_i || !ps2_i)      ack_pend_q <= 1'b0;
      if (!err_mask_i && err_fall)       err_pend_q <= 1'b1;
      else if (stat_rd_i)                err_pend_q <= 1'b0;
    end
  end

  assign ack_line   = ps2_i ? (ack_pend_q & ack_en_i) : (ack_en_i & ~ack_sync_i);
  assign irq_o      = ack_line | err_pend_q | svc_pend_i;
  assign stat2_o    = ps2_i ? ~ack_pend_q : 1'b1;
  assign ack_pend_o = ack_pend_q;
  assign ack_rise_o = ack_rise;
endmodule

// File: rtl/pport_core.sv
module pport_core
  import pport_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_re_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [DATA_W-1:0] pd_i,
  output logic [DATA_W-1:0] pd_o,
  output logic              pd_oe_o,
  output logic [3:0]        ctl_o,
  input  logic              ack_ni,
  input  logic              err_ni,
  input  logic              busy_i,
  input  logic              pe_i,
  input  logic              slct_i,
  input  logic              fifo_empty_i,
  input  logic              fifo_full_i,
  input  logic              fifo_svc_i,
  input  logic [2:0]        irq_sel_i,
  output logic              irq_o
);
  localparam int unsigned N_SYNC = 2;

  logic [DATA_W-1:0] data_q;
  logic [5:0]        ctl_q;
  logic [N_SYNC-1:0] pin_sync, pin_prev;
  logic [DATA_W-1:0] ecr_rdata, stat_rdata, cfgb_rdata;
  logic [2:0]        mode;
  logic              err_mask, svc_bit, svc_pend;
  logic              stat2, ack_pend, ack_rise, irq;
  logic              wr_data, wr_ctrl, wr_ecr, rd_stat;

  assign wr_data = bus_we_i && (bus_addr_i == OFF_DATA);
  assign wr_ctrl = bus_we_i && (bus_addr_i == OFF_CTRL);
  assign wr_ecr  = bus_we_i && (bus_addr_i == OFF_ECR);
  assign rd_stat = bus_re_i && (bus_addr_i == OFF_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      ctl_q  <= '0;
    end else begin
      if (wr_data) data_q <= bus_wdata_i;
      if (wr_ctrl) ctl_q  <= bus_wdata_i[5:0];
    end
  end

  pport_sync #(.W(N_SYNC), .RST_VAL(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({err_ni, ack_ni}),
    .sync_o (pin_sync),
    .prev_o (pin_prev)
  );

  pport_ecr u_ecr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (wr_ecr),
    .wdata_i      (bus_wdata_i),
    .fifo_empty_i (fifo_empty_i),
    .fifo_full_i  (fifo_full_i),
    .fifo_svc_i   (fifo_svc_i),
    .rdata_o      (ecr_rdata),
    .mode_o       (mode),
    .err_mask_o   (err_mask),
    .svc_bit_o    (svc_bit),
    .svc_pend_o   (svc_pend)
  );

  pport_irq u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ps2_i      (mode == MODE_PS2),
    .ack_en_i   (ctl_q[4]),
    .err_mask_i (err_mask),
    .ack_sync_i (pin_sync[0]),
    .ack_prev_i (pin_prev[0]),
    .err_sync_i (pin_sync[1]),
    .err_prev_i (pin_prev[1]),
    .stat_rd_i  (rd_stat),
    .svc_pend_i (svc_pend),
    .irq_o      (irq),
    .stat2_o    (stat2),
    .ack_pend_o (ack_pend),
    .ack_rise_o (ack_rise)
  );

  assign stat_rdata = {~busy_i, pin_sync[0], pe_i, slct_i, pin_sync[1], stat2, 2'b11};
  assign cfgb_rdata = (mode == MODE_CFG) ? {1'b0, irq, irq_sel_i, 3'b000} : 8'hFF;

  always_comb begin
    case (bus_addr_i)
      OFF_DATA: bus_rdata_o = ctl_q[5] ? pd_i : data_q;
      OFF_STAT: bus_rdata_o = stat_rdata;
      OFF_CTRL: bus_rdata_o = {2'b11, ctl_q};
      OFF_CFGB: bus_rdata_o = cfgb_rdata;
      OFF_ECR:  bus_rdata_o = ecr_rdata;
      default:  bus_rdata_o = 8'hFF;
    endcase
  end

  assign pd_o    = data_q;
  assign pd_oe_o = ~ctl_q[5];
  assign ctl_o   = ctl_q[3:0];
  assign irq_o   = irq;
endmodule

// File: rtl/pport_core_chk.sv
module pport_core_chk
  import pport_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_re_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic [DATA_W-1:0] pd_i,
  input logic              pd_oe_o,
  input logic              fifo_empty_i,
  input logic              fifo_full_i,
  input logic              fifo_svc_i,
  input logic              irq_o,
  input logic [2:0]        mode,
  input logic              ack_pend,
  input logic              ack_rise,
  input logic              ack_en,
  input logic              svc_bit
);
  logic rd_stat, ps2;
  assign rd_stat = bus_re_i && (bus_addr_i == OFF_STAT);
  assign ps2     = (mode == MODE_PS2);

  AST_DIR_READS_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_re_i && bus_addr_i == OFF_DATA && !pd_oe_o) |-> bus_rdata_o == pd_i); // R2
  AST_STAT_RD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat && !(ps2 && ack_en && ack_rise)) |=> !ack_pend); // R4
  AST_NONPS2_STAT2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat && !ps2) |-> bus_rdata_o[2]); // R5
  AST_ECR_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_re_i && bus_addr_i == OFF_ECR) |-> bus_rdata_o[1:0] == {fifo_full_i, fifo_empty_i}); // R6
  AST_CFGB_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_re_i && bus_addr_i == OFF_CFGB && mode != MODE_CFG) |-> bus_rdata_o == 8'hFF); // R8
  AST_SVC_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_svc_i && !svc_bit && !(bus_we_i && bus_addr_i == OFF_ECR)) |=> (svc_bit && irq_o)); // R10
endmodule

bind pport_core pport_core_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_re_i     (bus_re_i),
  .bus_we_i     (bus_we_i),
  .bus_addr_i   (bus_addr_i),
  .bus_rdata_o  (bus_rdata_o),
  .pd_i         (pd_i),
  .pd_oe_o      (pd_oe_o),
  .fifo_empty_i (fifo_empty_i),
  .fifo_full_i  (fifo_full_i),
  .fifo_svc_i   (fifo_svc_i),
  .irq_o        (irq_o),
  .mode         (mode),
  .ack_pend     (ack_pend),
  .ack_rise     (ack_rise),
  .ack_en       (ctl_q[4]),
  .svc_bit      (svc_bit)
);

// File: tb/pport_core_bench.sv
module pport_core_bench;
  import pport_pkg::*;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              bus_re_i = 1'b0, bus_we_i = 1'b0;
  logic [ADDR_W-1:0] bus_addr_i = '0;
  logic [DATA_W-1:0] bus_wdata_i = '0, bus_rdata_o, pd_i = '0, pd_o;
  logic              pd_oe_o, irq_o;
  logic [3:0]        ctl_o;
  logic              ack_ni = 1'b1, err_ni = 1'b1;
  logic              fifo_empty_i = 1'b1, fifo_full_i = 1'b0, fifo_svc_i = 1'b0;
  logic [2:0]        irq_sel_i = 3'd3;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pport_core u_pport_core (
    .clk_i(clk), .rst_ni(rst_ni), .bus_re_i(bus_re_i), .bus_we_i(bus_we_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .pd_i(pd_i), .pd_o(pd_o), .pd_oe_o(pd_oe_o), .ctl_o(ctl_o),
    .ack_ni(ack_ni), .err_ni(err_ni), .busy_i(1'b0), .pe_i(1'b0), .slct_i(1'b1),
    .fifo_empty_i(fifo_empty_i), .fifo_full_i(fifo_full_i), .fifo_svc_i(fifo_svc_i),
    .irq_sel_i(irq_sel_i), .irq_o(irq_o)
  );

  // {write, offset, wdata, expected read}
  localparam int NV = 8;
  localparam logic [27:0] VEC [NV] = '{
    {1'b1, 11'h000, 8'hA5, 8'hA5},  // R1
    {1'b1, 11'h000, 8'h5A, 8'h5A},  // R1
    {1'b1, 11'h002, 8'h0F, 8'hCF},  // R12
    {1'b1, 11'h402, 8'h34, 8'h35},  // R6
    {1'b1, 11'h402, 8'hF7, 8'hF5},  // R7
    {1'b0, 11'h401, 8'h00, 8'h18},  // R8
    {1'b1, 11'h402, 8'h14, 8'h15},  // R6
    {1'b0, 11'h401, 8'h00, 8'hFF}   // R8
  };

  function automatic string vtag(int i);
    case (i)
      0, 1: return "R1";
      2: return "R12";
      3, 6: return "R6";
      4: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_re_i = 1'b1; bus_addr_i = a;
    #1 d = bus_rdata_o;
    @(negedge clk);
    bus_re_i = 1'b0;
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    wait_n(20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    wait_n(3);
    rst_ni = 1'b1;
    wait_n(1);
    // R11 reset state
    check("R11", {7'd0, pd_oe_o}, 8'h01);
    check("R11", {7'd0, irq_o}, 8'h00);
    rd(OFF_CTRL, r); check("R11", r, 8'hC0);
    rd(OFF_ECR, r);  check("R11", r, 8'h15);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][27]) wr(VEC[i][26:16], VEC[i][15:8]);
      rd(VEC[i][26:16], r);
      check(vtag(i), r, VEC[i][7:0]);
    end
    check("R12", {4'd0, ctl_o}, 8'h0F);

    // R2 release and read pins; R1 latch kept
    pd_i = 8'h3C;
    wr(OFF_CTRL, 8'h20);
    rd(OFF_DATA, r); check("R2", r, 8'h3C);
    check("R2", {7'd0, pd_oe_o}, 8'h00);
    wr(OFF_DATA, 8'h77);
    wr(OFF_CTRL, 8'h00);
    rd(OFF_DATA, r); check("R1", r, 8'h77);
    check("R1", pd_o, 8'h77);

    // R3/R4 bidirectional mode
    wr(OFF_ECR, 8'h34);
    wr(OFF_CTRL, 8'h10);
    ack_ni = 1'b0; wait_n(4);
    check("R3", {7'd0, irq_o}, 8'h00);
    ack_ni = 1'b1; wait_n(4);
    check("R3", {7'd0, irq_o}, 8'h01);
    rd(OFF_STAT, r); check("R4", {7'd0, r[2]}, 8'h00);
    check("R4", {7'd0, irq_o}, 8'h00);
    rd(OFF_STAT, r); check("R4", {7'd0, r[2]}, 8'h01);
    wr(OFF_CTRL, 8'h00);
    ack_ni = 1'b0; wait_n(4); ack_ni = 1'b1; wait_n(4);
    check("R3", {7'd0, irq_o}, 8'h00);

    // R5 mirror in output mode
    wr(OFF_ECR, 8'h14);
    wr(OFF_CTRL, 8'h10);
    ack_ni = 1'b0; wait_n(4);
    check("R5", {7'd0, irq_o}, 8'h01);
    rd(OFF_STAT, r); check("R5", {7'd0, r[2]}, 8'h01);
    check("R5", {7'd0, irq_o}, 8'h01);
    ack_ni = 1'b1; wait_n(4);
    check("R5", {7'd0, irq_o}, 8'h00);
    wr(OFF_CTRL, 8'h00);

    // R9 error source
    err_ni = 1'b0; wait_n(4);
    check("R9", {7'd0, irq_o}, 8'h00);
    err_ni = 1'b1; wait_n(4);
    wr(OFF_ECR, 8'h04);
    err_ni = 1'b0; wait_n(4);
    check("R9", {7'd0, irq_o}, 8'h01);
    wr(OFF_ECR, 8'hE4);
    rd(OFF_CFGB, r); check("R8", r, 8'h58);
    rd(OFF_STAT, r);
    check("R9", {7'd0, irq_o}, 8'h00);
    err_ni = 1'b1; wait_n(4);
    check("R9", {7'd0, irq_o}, 8'h00);

    // R10 FIFO service
    wr(OFF_ECR, 8'h14);
    @(negedge clk); fifo_svc_i = 1'b1; @(negedge clk); fifo_svc_i = 1'b0;
    check("R10", {7'd0, irq_o}, 8'h00);
    wr(OFF_ECR, 8'h10);
    rd(OFF_ECR, r); check("R10", r, 8'h11);
    @(negedge clk); fifo_svc_i = 1'b1; @(negedge clk); fifo_svc_i = 1'b0;
    check("R10", {7'd0, irq_o}, 8'h01);
    rd(OFF_ECR, r); check("R10", r, 8'h15);
    wr(OFF_ECR, 8'h14);
    check("R10", {7'd0, irq_o}, 8'h00);

    // R6 full flag
    fifo_empty_i = 1'b0; fifo_full_i = 1'b1;
    rd(OFF_ECR, r); check("R6", r, 8'h16);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule